// File: doc/BRIEF.md
# Descriptor Ring Cursor Tracker

This block holds the cursor state of a single power-of-two descriptor submission ring. It keeps a producer index, a consumer counter and a 2-bit phase id. Software asks it for descriptor slots one at a time and, when a batch is known to be finished, acknowledges that batch with a count.

An allocation returns the producer slot and the phase to tag it with, then moves the producer forward. When the producer wraps back to slot 0, the stored phase steps by one modulo 4. The slot that wrapped keeps the old phase. The consumer counter moves only when a batch is acknowledged; no hardware completion entry ever touches it.

The free-slot output always holds back a 16-slot guard gap between producer and consumer. The ring size comes from a configuration input. Acknowledges are refused while that size is not a power of two.

Top module: `ring_cursor_tracker`

## Requirements
- R1: After reset the producer index and consumer counter are 0 and the phase is 1.
- R2: `free_cnt_o` equals (consumer - (producer + 16)) & mask at all times, where mask = ring size - 1.
- R3: A granted allocation presents the current producer index on `alloc_idx_o` in the request cycle. At the next clock edge the producer becomes (producer + 1) & mask.
- R4: `alloc_phase_o` shows the stored phase, which is the value before any increment. When a granted allocation moves the producer to 0, the stored phase becomes (phase + 1) & 3 at the next edge.
- R5: A granted acknowledge of N sets the consumer to (consumer + N) & mask at the next clock edge.
- R6: While the ring size is not a non-zero power of two, an acknowledge request gets `ack_gnt_o` low and `ack_err_o` high in the same cycle, and the consumer does not change.
- R7: While `free_cnt_o` is 0, an allocation request gets `alloc_gnt_o` low, and the producer and phase do not change.
- R8: An allocation and an acknowledge granted in the same cycle are both applied at the next edge.
- R9: In a cycle with no granted request, the producer, consumer and phase keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_size_i | input | IDX_W+1 | Configured ring size in slots |
| alloc_req_i | input | 1 | Request one descriptor slot |
| alloc_gnt_o | output | 1 | Allocation granted this cycle |
| alloc_idx_o | output | IDX_W | Slot index handed out |
| alloc_phase_o | output | 2 | Phase id for the handed-out slot |
| ack_req_i | input | 1 | Acknowledge a finished batch |
| ack_cnt_i | input | IDX_W | Batch size being acknowledged |
| ack_gnt_o | output | 1 | Acknowledge accepted this cycle |
| ack_err_o | output | 1 | Acknowledge refused: size not a power of two |
| free_cnt_o | output | IDX_W | Usable free slots after the guard gap |
| prod_idx_o | output | IDX_W | Producer index |
| cons_idx_o | output | IDX_W | Consumer counter |
| phase_o | output | 2 | Stored phase id |

## Verification
The grant, error, slot index, returned phase and free count are combinational. They are due in the same cycle as the request. The bench applies inputs on the falling edge and samples these outputs 1 ns later. The producer, consumer and phase registers change at the next rising edge. The bench samples them 1 ns after that edge and compares them with its own model, which has been advanced by the grants it expected. The free count derived from the new cursors is rechecked on the falling edge that follows.

// File: rtl/ring_cursor_pkg.sv
package ring_cursor_pkg;
  localparam int unsigned PHASE_W   = 2;
  typedef logic [PHASE_W-1:0] phase_t;
  localparam phase_t      PHASE_RST = phase_t'(1);
endpackage

// File: rtl/ring_size_decode.sv
module ring_size_decode #(
  parameter int unsigned IDX_W = 13
) (
  input  logic [IDX_W:0]   size_i,
  output logic [IDX_W-1:0] mask_o,
  output logic             pow2_o
);
  logic [IDX_W:0] size_m1;

  assign size_m1 = size_i - {{IDX_W{1'b0}}, 1'b1};
  assign mask_o  = size_m1[IDX_W-1:0];
  assign pow2_o  = (size_i != '0) && ((size_i & size_m1) == '0);

  always_comb begin
    if (pow2_o) assert ($countones(size_i) == 1) else $error("pow2 decode wrong");
  end
endmodule

// File: rtl/ring_prod_cursor.sv
module ring_prod_cursor
  import ring_cursor_pkg::*;
#(
  parameter int unsigned IDX_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [IDX_W-1:0] idx_o,
  output phase_t           phase_o
);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q, idx_nxt;
  phase_t           phase_q;
  logic             wrap;

  assign idx_nxt = (idx_q + IDX_ONE) & mask_i;
  assign wrap    = step_i && (idx_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PHASE_RST;
    end else begin
      if (step_i) idx_q <= idx_nxt;
      if (wrap)   phase_q <= phase_q + phase_t'(1);
    end
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_q;

  p_prod_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> idx_q == (($past(idx_q) + IDX_ONE) & $past(mask_i)));
  p_phase_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (((idx_q + IDX_ONE) & mask_i) == '0)) |=> phase_q == phase_t'($past(phase_q) + phase_t'(1)));
  p_prod_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q) && $stable(phase_q));
endmodule

// File: rtl/ring_cons_cursor.sv
module ring_cons_cursor #(
  parameter int unsigned IDX_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [IDX_W-1:0] cnt_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= (idx_q + cnt_i) & mask_i;
  end

  assign idx_o = idx_q;

  p_cons_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> idx_q == (($past(idx_q) + $past(cnt_i)) & $past(mask_i)));
  p_cons_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q));
endmodule

// File: rtl/ring_free_calc.sv
module ring_free_calc #(
  parameter int unsigned IDX_W = 13,
  parameter int unsigned GUARD = 16
) (
  input  logic [IDX_W-1:0] prod_i,
  input  logic [IDX_W-1:0] cons_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [IDX_W-1:0] free_o
);
  localparam logic [IDX_W-1:0] GUARD_V = IDX_W'(GUARD);

  // guard slots are counted as permanently taken
  assign free_o = (cons_i - (prod_i + GUARD_V)) & mask_i;
endmodule

// File: rtl/ring_cursor_tracker.sv
module ring_cursor_tracker
  import ring_cursor_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  parameter int unsigned GUARD = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W:0]   ring_size_i,
  input  logic             alloc_req_i,
  output logic             alloc_gnt_o,
  output logic [IDX_W-1:0] alloc_idx_o,
  output logic [1:0]       alloc_phase_o,
  input  logic             ack_req_i,
  input  logic [IDX_W-1:0] ack_cnt_i,
  output logic             ack_gnt_o,
  output logic             ack_err_o,
  output logic [IDX_W-1:0] free_cnt_o,
  output logic [IDX_W-1:0] prod_idx_o,
  output logic [IDX_W-1:0] cons_idx_o,
  output logic [1:0]       phase_o
);
  logic [IDX_W-1:0] mask;
  logic             pow2;
  logic [IDX_W-1:0] prod, cons, free_cnt;
  phase_t           phase;

  ring_size_decode #(.IDX_W(IDX_W)) u_dec (
    .size_i(ring_size_i), .mask_o(mask), .pow2_o(pow2)
  );

  ring_prod_cursor #(.IDX_W(IDX_W)) u_prod (
    .clk_i, .rst_ni, .step_i(alloc_gnt_o), .mask_i(mask),
    .idx_o(prod), .phase_o(phase)
  );

  ring_cons_cursor #(.IDX_W(IDX_W)) u_cons (
    .clk_i, .rst_ni, .step_i(ack_gnt_o), .cnt_i(ack_cnt_i), .mask_i(mask),
    .idx_o(cons)
  );

  ring_free_calc #(.IDX_W(IDX_W), .GUARD(GUARD)) u_free (
    .prod_i(prod), .cons_i(cons), .mask_i(mask), .free_o(free_cnt)
  );

  assign alloc_gnt_o   = alloc_req_i && (free_cnt != '0);
  assign alloc_idx_o   = prod;
  assign alloc_phase_o = phase;
  assign ack_gnt_o     = ack_req_i && pow2;
  assign ack_err_o     = ack_req_i && !pow2;
  assign free_cnt_o    = free_cnt;
  assign prod_idx_o    = prod;
  assign cons_idx_o    = cons;
  assign phase_o       = phase;

  p_ack_refuse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_i && !pow2) |=> $stable(cons));
  p_full_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_req_i && free_cnt == '0) |=> $stable(prod) && $stable(phase));
  p_both_apply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_gnt_o && ack_gnt_o) |=>
      (prod == (($past(prod) + IDX_W'(1)) & $past(mask))) &&
      (cons == (($past(cons) + $past(ack_cnt_i)) & $past(mask))));
endmodule

// File: tb/ring_cursor_tracker_tb.sv
module ring_cursor_tracker_tb;
  localparam int IDX_W = 13;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IDX_W:0]   ring_size = 14'd32;
  logic             alloc_req = 1'b0, ack_req = 1'b0;
  logic [IDX_W-1:0] ack_cnt = '0;
  logic             alloc_gnt, ack_gnt, ack_err;
  logic [IDX_W-1:0] alloc_idx, free_cnt, prod_idx, cons_idx;
  logic [1:0]       alloc_phase, phase;

  int checks = 0, failures = 0;
  int m_prod, m_cons, m_phase;
  bit done = 0;

  always #2 clk = ~clk;

  ring_cursor_tracker #(.IDX_W(IDX_W), .GUARD(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ring_size_i(ring_size),
    .alloc_req_i(alloc_req), .alloc_gnt_o(alloc_gnt), .alloc_idx_o(alloc_idx),
    .alloc_phase_o(alloc_phase), .ack_req_i(ack_req), .ack_cnt_i(ack_cnt),
    .ack_gnt_o(ack_gnt), .ack_err_o(ack_err), .free_cnt_o(free_cnt),
    .prod_idx_o(prod_idx), .cons_idx_o(cons_idx), .phase_o(phase)
  );

  function automatic int mask_of(int s);
    return (s - 1) & ((1 << IDX_W) - 1);
  endfunction
  function automatic bit pow2_of(int s);
    return (s != 0) && ((s & (s - 1)) == 0);
  endfunction
  function automatic int free_of(int p, int c, int s);
    return (c - (p + 16)) & mask_of(s);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst_ni = 1'b0; alloc_req = 0; ack_req = 0; ring_size = (IDX_W+1)'(s);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_prod = 0; m_cons = 0; m_phase = 1;
    #1;
    chk("R1 prod", int'(prod_idx), 0);
    chk("R1 cons", int'(cons_idx), 0);
    chk("R1 phase", int'(phase), 1);
    chk("R2 free after reset", int'(free_cnt), free_of(0, 0, s));
  endtask

  task automatic step(input bit a, input bit k, input int n);
    int  s, fe;
    bit  ge, kg;
    @(negedge clk);
    alloc_req = a; ack_req = k; ack_cnt = IDX_W'(n);
    #1;
    s  = int'(ring_size);
    fe = free_of(m_prod, m_cons, s);
    ge = a && (fe != 0);
    kg = k && pow2_of(s);
    chk("R2 free", int'(free_cnt), fe);
    chk("R7 alloc grant", int'(alloc_gnt), int'(ge));
    if (ge) chk("R3 alloc idx", int'(alloc_idx), m_prod);
    chk("R4 returned phase", int'(alloc_phase), m_phase);
    chk("R6 ack grant", int'(ack_gnt), int'(kg));
    chk("R6 ack error", int'(ack_err), int'(k && !pow2_of(s)));
    @(posedge clk);
    if (ge) begin
      m_prod = (m_prod + 1) & mask_of(s);
      if (m_prod == 0) m_phase = (m_phase + 1) & 3;
    end
    if (kg) m_cons = (m_cons + n) & mask_of(s);
    #1;
    if (ge && kg) begin
      chk("R8 prod", int'(prod_idx), m_prod);
      chk("R8 cons", int'(cons_idx), m_cons);
    end else begin
      chk(ge ? "R3 prod" : "R9 prod", int'(prod_idx), m_prod);
      chk(kg ? "R5 cons" : "R9 cons", int'(cons_idx), m_cons);
    end
    chk("R4 stored phase", int'(phase), m_phase);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // size 32: 16 usable slots after the guard
    do_reset(32);
    for (int i = 0; i < 16; i++) step(1, 0, 0);
    chk("R7 free at zero", int'(free_cnt), 0);
    step(1, 0, 0);                        // refused when full
    step(0, 1, 10);                       // ack 10
    step(1, 1, 3);                        // both in one cycle
    // drive producer through several wraps
    for (int i = 0; i < 200; i++) step(1, 1, 1);
    // size not a power of two: ack refused
    do_reset(32);
    step(0, 1, 4);
    @(negedge clk); ring_size = 14'd48;
    step(0, 1, 5);
    step(0, 1, 1);
    chk("R6 cons unchanged", int'(cons_idx), 4);
    // random traffic at sizes 64 and 8192
    do_reset(64);
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 7, ($urandom % 10) < 4, int'($urandom % 6));
    do_reset(8192);
    for (int i = 0; i < 2000; i++)
      step(($urandom % 10) < 8, ($urandom % 10) < 3, int'($urandom % 5));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule